// File: doc/BRIEF.md
# Interval Timer Register Interface

This block is the byte-wide bus front end of a three-channel programmable interval timer. A 2-bit address picks one of three channel data ports (0 to 2) or the write-only control port (3). Control writes either configure a channel (access mode, counting mode, decimal flag), freeze a channel's count for later reading, or issue a multi-channel read-back command that can freeze count and status of several channels at once.

Writes to a channel data port are assembled into an initial count according to the channel's access mode and handed to the counter core as a one-cycle load strobe with a 17-bit value. A written count of zero is delivered as 65536. Reads return, in order of priority, a frozen status byte, a frozen count, or the live count supplied by the core. In word mode the byte order is low first, then high. The counting itself, decimal counting and the null-count status bit are outside this block. All accesses are synchronous, with single-cycle read and write strobes and a synchronous reset.

Top module: `timer_regif`

## Requirements
- R1: After reset every channel is in low-byte-only access mode (code 1) with counting mode 0, nothing is frozen, `loadStb` is 0 and a read of a channel returns the low byte of its live count.
- R2: A data write in low-only mode (access 1) loads the byte as the count. In high-only mode (access 2) it loads the byte times 256. A zero count is delivered as 65536 (bit 16 set). `loadCount` of channel n sits at bits [17n+16:17n].
- R3: In word mode (access 3) the first data write loads nothing and is held. The second write loads {second, first}, and the next write is taken as a low byte again. A configuring control word returns the write sequence to the low byte.
- R4: A control word with channel field bits 7:6 below 3 and access bits 5:4 nonzero sets that channel's access mode and counting mode (bits 3:1, shown on `modeOut` bits [3n+2:3n]) and its decimal flag (bit 0). Access 0 is a count-freeze command and leaves the mode unchanged.
- R5: A count freeze captures the live count. A further freeze while one is held is ignored. A frozen count reads in word mode as low byte, then high byte, then it releases. In a single-byte mode it releases after one read (low byte for access 1, high byte for access 2).
- R6: A read-back command (bits 7:6 = 3) acts on channel n when bit n+1 is set. It freezes the count when bit 5 is 0 and the status when bit 4 is 0. The status byte is {output level, 0, access[1:0], mode[2:0], decimal flag}, captured at the command.
- R7: A held status is read before a held count and releases after one read. A status held is not replaced by a later status request.
- R8: Unfrozen reads give the live low byte in access 1 and the live high byte in access 2. In access 3 they alternate low, high, starting at low after a configuring control word.
- R9: A read of address 3 returns 0.
- R10: `loadStb` is high for exactly the cycle after an accepted count-completing data write. Control-port writes never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst | input | 1 | synchronous reset, active high |
| addr | input | 2 | 0..2 channel data port, 3 control port |
| wrEn | input | 1 | single-cycle write strobe |
| wrData | input | 8 | write byte |
| rdEn | input | 1 | single-cycle read strobe |
| rdData | output | 8 | read byte, valid in the cycle `rdEn` is high |
| liveCount | input | 48 | current count of each core, 16 bits per channel |
| outLevel | input | 3 | output level of each core |
| loadStb | output | 3 | per-channel count load strobe |
| loadCount | output | 51 | per-channel 17-bit initial count |
| modeOut | output | 9 | per-channel counting mode, 3 bits each |

## Verification
Count writes are swept over every channel and every access mode with the byte values 00, 01, 7F and FF. The values include zero, so the 65536 substitution can be told apart from a plain byte load, and the word pairs are asymmetric, so a byte-order swap shows up. Freeze tests change the live count between a freeze, a repeated freeze and the reads. This shows whether a capture is held, overwritten or bypassed. Read-back tests change the output level and the counts after the command and repeat the command, so that status-before-count priority, the per-channel select bits and the status field positions each give a distinct byte.

// File: rtl/timer_regif_pkg.sv
`timescale 1ns/1ps
package timer_regif_pkg;
  localparam int NUM_CH  = 3;            // fixed by the read-back select bits
  localparam int CNT_W   = 16;
  localparam int LOAD_W  = CNT_W + 1;
  localparam int MODE_W  = 3;
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  localparam logic [1:0] ACC_LATCH = 2'd0;
  localparam logic [1:0] ACC_LO    = 2'd1;
  localparam logic [1:0] ACC_HI    = 2'd2;
  localparam logic [1:0] ACC_WORD  = 2'd3;

  typedef enum logic [1:0] {
    HOLD_NONE = 2'd0,
    HOLD_LO   = 2'd1,
    HOLD_HI   = 2'd2,
    HOLD_WORD = 2'd3
  } holdSt_t;

  typedef struct packed {
    logic [NUM_CH-1:0] cfgWr;
    logic [NUM_CH-1:0] latchCnt;
    logic [NUM_CH-1:0] latchSts;
    logic [NUM_CH-1:0] dataWr;
    logic [NUM_CH-1:0] dataRd;
  } regStb_t;
endpackage

// File: rtl/timer_regif_ctrl.sv
`timescale 1ns/1ps
module timer_regif_ctrl
  import timer_regif_pkg::*;
(
  input  logic [1:0] addr,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:1] ctrlByte,
  output regStb_t    stb
);
  logic [1:0] chSel;
  logic [1:0] accSel;
  assign chSel  = ctrlByte[7:6];
  assign accSel = ctrlByte[5:4];

  always_comb begin
    stb = '0;
    if (wrEn) begin
      if (addr == CTRL_ADDR) begin
        if (chSel == 2'd3) begin
          for (int ch = 0; ch < NUM_CH; ch++) begin
            if (ctrlByte[ch+1]) begin
              stb.latchCnt[ch] = !ctrlByte[5];
              stb.latchSts[ch] = !ctrlByte[4];
            end
          end
        end else if (accSel == ACC_LATCH) begin
          stb.latchCnt[chSel] = 1'b1;
        end else begin
          stb.cfgWr[chSel] = 1'b1;
        end
      end else begin
        stb.dataWr[addr] = 1'b1;
      end
    end
    if (rdEn && addr != CTRL_ADDR) begin
      stb.dataRd[addr] = 1'b1;
    end
  end
endmodule

// File: rtl/timer_regif_dp.sv
`timescale 1ns/1ps
module timer_regif_dp
  import timer_regif_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  regStb_t                  stb,
  input  logic [7:0]               wrData,
  input  logic [NUM_CH*CNT_W-1:0]  liveCount,
  input  logic [NUM_CH-1:0]        outLevel,
  output logic [7:0]               rdData,
  output logic [NUM_CH-1:0]        loadStb,
  output logic [NUM_CH*LOAD_W-1:0] loadCount,
  output logic [NUM_CH*MODE_W-1:0] modeOut
);
  logic [NUM_CH*8-1:0] chanBytes;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [1:0]        acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
    logic              wrHiNext;
    logic              rdHiNext;
    logic [7:0]        lowHold;
    holdSt_t           cntSt;
    logic [CNT_W-1:0]  cntHold;
    logic              stsHeld;
    logic [7:0]        stsHold;
    logic              ldStbR;
    logic [LOAD_W-1:0] ldCntR;
    logic [CNT_W-1:0]  live;
    logic [CNT_W-1:0]  rawCnt;
    logic              doLoad;
    logic [LOAD_W-1:0] nextLoad;
    logic [7:0]        byteOut;

    assign live = liveCount[i*CNT_W +: CNT_W];

    always_comb begin
      doLoad = 1'b0;
      rawCnt = '0;
      if (stb.dataWr[i]) begin
        case (acc)
          ACC_HI: begin
            doLoad = 1'b1;
            rawCnt = {wrData, 8'h00};
          end
          ACC_WORD: begin
            doLoad = wrHiNext;
            rawCnt = {wrData, lowHold};
          end
          default: begin
            doLoad = 1'b1;
            rawCnt = {8'h00, wrData};
          end
        endcase
      end
      nextLoad = (rawCnt == '0) ? (LOAD_W'(1) << CNT_W) : {1'b0, rawCnt};
    end

    always_comb begin
      if (stsHeld) begin
        byteOut = stsHold;
      end else begin
        case (cntSt)
          HOLD_LO, HOLD_WORD: byteOut = cntHold[7:0];
          HOLD_HI:            byteOut = cntHold[15:8];
          default: begin
            case (acc)
              ACC_HI:   byteOut = live[15:8];
              ACC_WORD: byteOut = rdHiNext ? live[15:8] : live[7:0];
              default:  byteOut = live[7:0];
            endcase
          end
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        acc      <= ACC_LO;
        mode     <= '0;
        bcd      <= 1'b0;
        wrHiNext <= 1'b0;
        rdHiNext <= 1'b0;
        lowHold  <= '0;
        cntSt    <= HOLD_NONE;
        cntHold  <= '0;
        stsHeld  <= 1'b0;
        stsHold  <= '0;
        ldStbR   <= 1'b0;
        ldCntR   <= '0;
      end else begin
        ldStbR <= doLoad;
        if (doLoad) ldCntR <= nextLoad;

        if (stb.cfgWr[i]) begin
          acc      <= wrData[5:4];
          mode     <= wrData[3:1];
          bcd      <= wrData[0];
          wrHiNext <= 1'b0;
          rdHiNext <= 1'b0;
        end

        if (stb.dataWr[i] && acc == ACC_WORD) begin
          if (!wrHiNext) lowHold <= wrData;
          wrHiNext <= !wrHiNext;
        end

        if (stb.latchCnt[i] && cntSt == HOLD_NONE) begin
          cntHold <= live;
          case (acc)
            ACC_HI:   cntSt <= HOLD_HI;
            ACC_WORD: cntSt <= HOLD_WORD;
            default:  cntSt <= HOLD_LO;
          endcase
        end

        if (stb.latchSts[i] && !stsHeld) begin
          stsHeld <= 1'b1;
          stsHold <= {outLevel[i], 1'b0, acc, mode, bcd};
        end

        if (stb.dataRd[i]) begin
          if (stsHeld) begin
            stsHeld <= 1'b0;
          end else if (cntSt != HOLD_NONE) begin
            cntSt <= (cntSt == HOLD_WORD) ? HOLD_HI : HOLD_NONE;
          end else if (acc == ACC_WORD) begin
            rdHiNext <= !rdHiNext;
          end
        end
      end
    end

    assign chanBytes[i*8 +: 8]              = byteOut;
    assign loadStb[i]                       = ldStbR;
    assign loadCount[i*LOAD_W +: LOAD_W]    = ldCntR;
    assign modeOut[i*MODE_W +: MODE_W]      = mode;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (stb.dataRd[i]) rdData = rdData | chanBytes[i*8 +: 8];
    end
  end
endmodule

// File: rtl/timer_regif.sv
`timescale 1ns/1ps
module timer_regif
  import timer_regif_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               addr,
  input  logic                     wrEn,
  input  logic [7:0]               wrData,
  input  logic                     rdEn,
  output logic [7:0]               rdData,
  input  logic [NUM_CH*CNT_W-1:0]  liveCount,
  input  logic [NUM_CH-1:0]        outLevel,
  output logic [NUM_CH-1:0]        loadStb,
  output logic [NUM_CH*LOAD_W-1:0] loadCount,
  output logic [NUM_CH*MODE_W-1:0] modeOut
);
  regStb_t stb;

  timer_regif_ctrl u_ctrl (
    .addr     (addr),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .ctrlByte (wrData[7:1]),
    .stb      (stb)
  );

  timer_regif_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .wrData    (wrData),
    .liveCount (liveCount),
    .outLevel  (outLevel),
    .rdData    (rdData),
    .loadStb   (loadStb),
    .loadCount (loadCount),
    .modeOut   (modeOut)
  );
endmodule

// File: rtl/timer_regif_chk.sv
`timescale 1ns/1ps
module timer_regif_chk
  import timer_regif_pkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic [1:0]               addr,
  input logic                     wrEn,
  input logic                     rdEn,
  input logic [7:0]               rdData,
  input logic [NUM_CH-1:0]        loadStb,
  input logic [NUM_CH*LOAD_W-1:0] loadCount
);
  // R9: the control port reads as zero
  p_ctl_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rdEn && addr == CTRL_ADDR) |-> (rdData == 8'h00));

  // R10: at most one channel loads per cycle
  p_load_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(loadStb));

  // R10: a load follows a data-port write
  p_load_from_data_r10: assert property (@(posedge clk) disable iff (rst)
    (loadStb != '0) |-> ($past(wrEn) && $past(addr) != CTRL_ADDR));

  // R10: control writes never load
  p_ctl_no_load_r10: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == CTRL_ADDR) |=> (loadStb == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R2: a delivered count is never zero and never above 65536
    p_load_range_r2: assert property (@(posedge clk) disable iff (rst)
      loadStb[i] |-> (loadCount[i*LOAD_W +: LOAD_W] != '0 &&
                      loadCount[i*LOAD_W +: LOAD_W] <= (LOAD_W'(1) << CNT_W)));
  end
endmodule

bind timer_regif timer_regif_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr      (addr),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .rdData    (rdData),
  .loadStb   (loadStb),
  .loadCount (loadCount)
);

// File: tb/sim_timer_regif.sv
`timescale 1ns/1ps
module sim_timer_regif;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic [47:0] liveCount = '0;
  logic [2:0]  outLevel = '0;
  logic [2:0]  loadStb;
  logic [50:0] loadCount;
  logic [8:0]  modeOut;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  timer_regif u0 (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .liveCount(liveCount), .outLevel(outLevel),
    .loadStb(loadStb), .loadCount(loadCount), .modeOut(modeOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expLoad(input int raw);
    return (raw == 0) ? 65536 : raw;
  endfunction

  // write; after it, loadStb/loadCount reflect the registered result
  task automatic wrByte(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkLoad(input string tag, input int ch, input int exp);
    // exp < 0 means no strobe expected
    if (exp < 0) check(tag, int'(loadStb), 0);
    else begin
      check(tag, int'(loadStb), 1 << ch);
      check(tag, int'(loadCount[ch*17 +: 17]), exp);
    end
  endtask

  task automatic rdByte(input logic [1:0] a, input string tag, input int exp);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #2;
    check(tag, int'(rdData), exp);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  function automatic logic [7:0] cfgWord(input int ch, input int acc, input int md, input int bcd);
    return 8'((ch << 6) | (acc << 4) | (md << 1) | bcd);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [4];
    vals[0] = 8'h00; vals[1] = 8'h01; vals[2] = 8'h7f; vals[3] = 8'hff;
    liveCount[15:0] = 16'h1234;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 loadStb", int'(loadStb), 0);
    check("R1 modeOut", int'(modeOut), 0);
    rdByte(2'd0, "R1 live low after reset", 8'h34);

    // R2 R3 R4 R10 sweep of writes
    for (int ch = 0; ch < 3; ch++) begin
      for (int acc = 1; acc <= 3; acc++) begin
        int md;
        md = (acc + ch) % 8;
        wrByte(2'd3, cfgWord(ch, acc, md, 0));
        checkLoad("R10 no load on control", ch, -1);
        check("R4 mode set", int'(modeOut[ch*3 +: 3]), md);
        for (int k = 0; k < 4; k++) begin
          if (acc == 1) begin
            wrByte(2'(ch), vals[k]);
            checkLoad("R2 low-only load", ch, expLoad(int'(vals[k])));
          end else if (acc == 2) begin
            wrByte(2'(ch), vals[k]);
            checkLoad("R2 high-only load", ch, expLoad(int'(vals[k]) << 8));
          end else begin
            wrByte(2'(ch), vals[k]);
            checkLoad("R3 first byte held", ch, -1);
            wrByte(2'(ch), vals[3-k]);
            checkLoad("R3 word load", ch, expLoad((int'(vals[3-k]) << 8) | int'(vals[k])));
          end
        end
      end
    end
    // R3 word zero
    wrByte(2'd2, 8'h00); wrByte(2'd2, 8'h00);
    checkLoad("R3 word zero", 2, 65536);

    // R3 configuring word resets write sequence
    wrByte(2'd3, cfgWord(1, 3, 0, 0));
    wrByte(2'd1, 8'h11);
    wrByte(2'd3, cfgWord(1, 3, 0, 0));
    wrByte(2'd1, 8'h22);
    checkLoad("R3 restart after config", 1, -1);
    wrByte(2'd1, 8'h33);
    checkLoad("R3 restart word", 1, 16'h3322);

    // R5 freeze in word mode, repeated freeze ignored, R4 mode kept
    wrByte(2'd3, cfgWord(0, 3, 2, 0));
    liveCount[15:0] = 16'hABCD;
    wrByte(2'd3, 8'h00);
    check("R4 latch keeps mode", int'(modeOut[2:0]), 2);
    liveCount[15:0] = 16'h1234;
    wrByte(2'd3, 8'h00);
    rdByte(2'd0, "R5 frozen low", 8'hCD);
    rdByte(2'd0, "R5 frozen high", 8'hAB);
    // R8 live alternation after release
    rdByte(2'd0, "R8 live low", 8'h34);
    rdByte(2'd0, "R8 live high", 8'h12);
    rdByte(2'd0, "R8 live low again", 8'h34);
    wrByte(2'd3, cfgWord(0, 3, 2, 0));
    rdByte(2'd0, "R8 config resets to low", 8'h34);

    // R5 single-byte freeze, high-only
    wrByte(2'd3, cfgWord(2, 2, 1, 0));
    liveCount[47:32] = 16'h5678;
    wrByte(2'd3, 8'h80);
    liveCount[47:32] = 16'h9ABC;
    rdByte(2'd2, "R5 frozen high-only", 8'h56);
    rdByte(2'd2, "R8 live high-only", 8'h9A);
    wrByte(2'd3, cfgWord(2, 1, 0, 0));
    rdByte(2'd2, "R8 live low-only", 8'hBC);

    // R6 read-back count only, channel 2
    liveCount[47:32] = 16'h4321;
    wrByte(2'd3, 8'hD8);
    liveCount[47:32] = 16'h8765;
    rdByte(2'd2, "R6 read-back count only", 8'h21);
    rdByte(2'd2, "R5 released after one byte", 8'h65);

    // R6 R7 read-back count and status on channels 0 and 1
    wrByte(2'd3, 8'h77);           // ch1 word, mode 3, decimal flag
    wrByte(2'd3, 8'h18);           // ch0 low-only, mode 4
    outLevel = 3'b010;
    liveCount[15:0]  = 16'h0102;
    liveCount[31:16] = 16'h0304;
    wrByte(2'd3, 8'hC6);
    outLevel = 3'b000;
    liveCount[15:0]  = 16'h0A0B;
    liveCount[31:16] = 16'h0C0D;
    wrByte(2'd3, 8'hC6);
    rdByte(2'd1, "R7 status first ch1", 8'hB7);
    rdByte(2'd1, "R6 count low ch1", 8'h04);
    rdByte(2'd1, "R6 count high ch1", 8'h03);
    rdByte(2'd1, "R8 live after release ch1", 8'h0D);
    rdByte(2'd0, "R7 status first ch0", 8'h18);
    rdByte(2'd0, "R6 count ch0", 8'h02);
    rdByte(2'd0, "R5 live after single release ch0", 8'h0B);
    // channel 2 not selected: live read
    rdByte(2'd2, "R6 unselected channel live", 8'h65);

    // R9
    rdByte(2'd3, "R9 control read zero", 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule